// File: doc/BRIEF.md
# Residue Number System Shift-Subtract Divider

This block divides a non-negative dividend by a non-negative divisor when both arrive as residue vectors over the moduli 5, 7, 9 and 11. Together these moduli span the range 0 to 3464. The block returns the quotient and the remainder, also as residue vectors.

Internally each operand is turned into a positional fraction of the full range. The fraction has 24 fractional bits and 2 bits of integer headroom. Working on these fractions, the block first finds the largest power of two in the quotient by repeatedly doubling the divisor fraction. It then walks back down one exponent per clock. Each step halves the divisor fraction and subtracts it from a running difference. When the result stays non-negative, the matching power of two is added to a quotient accumulator held in residue form.

The powers of two come from a residue table, so the quotient never needs a binary-to-residue conversion. The remainder is formed at the end as dividend − divisor·quotient, computed per modulus. A caller pulses `start` with both operands, waits for the one-cycle `done` pulse, and then reads the results.

Top module: `rns_divider`

## Requirements
- R1: While reset is applied, and until the first accepted start, `busy`, `done` and `divZeroErr` are low and both result vectors are zero.
- R2: When the dividend is smaller than the divisor, the quotient is 0 and the remainder equals the dividend.
- R3: When the dividend equals the divisor and is non-zero, the quotient is 1 and the remainder is 0.
- R4: For any dividend a and non-zero divisor b in 0..3464, the quotient residues equal floor(a/b) and the remainder residues equal a mod b. Every vector packs residue k in bits [4k+3:4k], with the moduli ordered 5, 7, 9, 11 from bit 0, and each field stays below its modulus.
- R5: Quotients up to 3464 are produced exactly, which needs a leading power of two up to 2^11.
- R6: `busy` rises in the cycle after an accepted start and falls in the same cycle in which `done` rises. `done` is high for exactly one cycle.
- R7: A start pulse that arrives while `busy` is high is ignored. Both result vectors change only in the cycle in which `done` rises.
- R8: A divisor whose residues are all zero raises `divZeroErr`, forces both result vectors to zero, and still produces a `done` pulse.
- R9: The next accepted start clears `divZeroErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a division when the block is idle |
| dividendRes | input | 16 | Dividend residue vector |
| divisorRes | input | 16 | Divisor residue vector |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse when the results are valid |
| divZeroErr | output | 1 | The last division had a zero divisor |
| quotientRes | output | 16 | Quotient residue vector |
| remainderRes | output | 16 | Remainder residue vector |

## Verification
The bench drives each kind of operand pair, and each one isolates a different path through the block:
- A dividend below the divisor, including a zero dividend, exercises the early-exit path.
- Equal operands exercise the direct quotient-of-one path.
- A pair whose quotient is 1 with a non-zero remainder exercises the setup stage ending without a single doubling (leading exponent 0).
- Mid-range pairs, some with exact and some with non-zero remainders, show that the fraction comparison decides each refinement bit correctly at the critical exact-fit boundary.
- A dividend of 3464 over divisors 1 and 2 reaches the highest table entries.
- A zero divisor, a start pulse issued while busy, and a run that follows an error separate the error handling and the handshake from the arithmetic.

// File: rtl/rns_div_pkg.sv
package rns_div_pkg;

  localparam int NUM_MOD = 4;
  localparam int RES_W   = 4;
  localparam int VEC_W   = NUM_MOD * RES_W;
  localparam int FRAC_W  = 24;
  localparam int INT_W   = 2;
  localparam int FX_W    = FRAC_W + INT_W;
  localparam int MAX_EXP = 11;
  localparam int EXP_W   = $clog2(MAX_EXP + 2);

  typedef int unsigned modList_t [NUM_MOD];
  localparam modList_t MODULI = '{5, 7, 9, 11};

  // strobes from control to datapath
  typedef struct packed {
    logic loadOps;
    logic shiftUp;
    logic initDiff;
    logic stepDown;
    logic setQuotOne;
    logic finishRem;
    logic flagZero;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic divZero;
    logic divGreater;
    logic divEqual;
    logic canDouble;
    logic expIsZero;
    logic lastStep;
  } dpStatus_t;

  function automatic int unsigned rangeOf();
    int unsigned p;
    p = 1;
    for (int k = 0; k < NUM_MOD; k++) p = p * MODULI[k];
    return p;
  endfunction

  localparam int unsigned RANGE = rangeOf();

  // CRT weight: M_k times its inverse modulo m_k
  function automatic int unsigned crtWeight(input int k);
    int unsigned mk;
    int unsigned inv;
    mk  = RANGE / MODULI[k];
    inv = 1;
    for (int t = 1; t < 16; t++) begin
      if (t < int'(MODULI[k]) && ((mk % MODULI[k]) * t) % MODULI[k] == 1) inv = t;
    end
    return mk * inv;
  endfunction

  // positional fraction X/RANGE with FRAC_W fractional bits (floor)
  function automatic logic [FX_W-1:0] toFraction(input logic [VEC_W-1:0] vec);
    longint unsigned acc;
    longint unsigned scaled;
    acc = 0;
    for (int k = 0; k < NUM_MOD; k++) begin
      acc = acc + longint'(vec[k*RES_W +: RES_W]) * longint'(crtWeight(k));
    end
    acc    = acc % longint'(RANGE);
    scaled = (acc << FRAC_W) / longint'(RANGE);
    return FX_W'(scaled);
  endfunction

  // 2^e mod m
  function automatic logic [RES_W-1:0] pow2Res(input logic [EXP_W-1:0] e, input int unsigned m);
    int unsigned r;
    r = 1;
    for (int i = 0; i < MAX_EXP; i++) begin
      if (i < int'(e)) r = (r * 2) % m;
    end
    return RES_W'(r);
  endfunction

  function automatic logic [RES_W-1:0] modAdd(input logic [RES_W-1:0] x, input logic [RES_W-1:0] y,
                                              input int unsigned m);
    int unsigned s;
    s = int'(x) + int'(y);
    if (s >= m) s = s - m;
    return RES_W'(s);
  endfunction

  // (a - b*q) mod m
  function automatic logic [RES_W-1:0] modMulSub(input logic [RES_W-1:0] a, input logic [RES_W-1:0] b,
                                                 input logic [RES_W-1:0] q, input int unsigned m);
    int unsigned p;
    int unsigned d;
    p = (int'(b) * int'(q)) % m;
    d = int'(a) + m - p;
    if (d >= m) d = d - m;
    return RES_W'(d);
  endfunction

endpackage

// File: rtl/rns_div_datapath.sv
module rns_div_datapath
  import rns_div_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [VEC_W-1:0]  dividendRes,
  input  logic [VEC_W-1:0]  divisorRes,
  output dpStatus_t         status,
  output logic              divZeroErr,
  output logic [VEC_W-1:0]  quotientRes,
  output logic [VEC_W-1:0]  remainderRes
);

  logic [VEC_W-1:0] aVec, bVec, accQ;
  logic [FX_W-1:0]  dividendFx, divisorFx, diffFx;
  logic [EXP_W-1:0] expIdx;

  logic [FX_W-1:0]  doubledFx, halvedFx;
  logic [FX_W:0]    trialFx;
  logic             trialOk;
  logic [VEC_W-1:0] qPlus, powInitVec, remVec;

  assign doubledFx = divisorFx << 1;
  assign halvedFx  = divisorFx >> 1;
  assign trialFx   = {1'b0, diffFx} - {1'b0, halvedFx};
  assign trialOk   = ~trialFx[FX_W];

  // per-modulus residue arithmetic
  for (genvar k = 0; k < NUM_MOD; k++) begin : g_mod
    localparam int unsigned M = MODULI[k];
    logic [RES_W-1:0] qCur, pStep;
    assign qCur  = accQ[k*RES_W +: RES_W];
    assign pStep = pow2Res(expIdx - EXP_W'(1), M);
    assign qPlus[k*RES_W +: RES_W]      = modAdd(qCur, pStep, M);
    assign powInitVec[k*RES_W +: RES_W] = pow2Res(expIdx, M);
    assign remVec[k*RES_W +: RES_W]     = modMulSub(aVec[k*RES_W +: RES_W],
                                                    bVec[k*RES_W +: RES_W], qCur, M);
  end

  assign status.divZero    = (bVec == '0);
  assign status.divGreater = (divisorFx > dividendFx);
  assign status.divEqual   = (divisorFx == dividendFx);
  assign status.canDouble  = (doubledFx <= dividendFx);
  assign status.expIsZero  = (expIdx == '0);
  assign status.lastStep   = (expIdx == EXP_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aVec         <= '0;
      bVec         <= '0;
      accQ         <= '0;
      dividendFx   <= '0;
      divisorFx    <= '0;
      diffFx       <= '0;
      expIdx       <= '0;
      divZeroErr   <= 1'b0;
      quotientRes  <= '0;
      remainderRes <= '0;
    end else begin
      if (strobe.loadOps) begin
        aVec       <= dividendRes;
        bVec       <= divisorRes;
        dividendFx <= toFraction(dividendRes);
        divisorFx  <= toFraction(divisorRes);
        expIdx     <= '0;
        accQ       <= '0;
        divZeroErr <= 1'b0;
      end
      if (strobe.shiftUp) begin
        divisorFx <= doubledFx;
        expIdx    <= expIdx + EXP_W'(1);
      end
      if (strobe.initDiff) begin
        diffFx <= dividendFx - divisorFx;
        accQ   <= powInitVec;
      end
      if (strobe.stepDown) begin
        divisorFx <= halvedFx;
        expIdx    <= expIdx - EXP_W'(1);
        if (trialOk) begin
          diffFx <= trialFx[FX_W-1:0];
          accQ   <= qPlus;
        end
      end
      if (strobe.setQuotOne) begin
        accQ <= {NUM_MOD{RES_W'(1)}};
      end
      if (strobe.finishRem) begin
        quotientRes  <= accQ;
        remainderRes <= remVec;
      end
      if (strobe.flagZero) begin
        quotientRes  <= '0;
        remainderRes <= '0;
        divZeroErr   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rns_div_control.sv
module rns_div_control
  import rns_div_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done
);

  typedef enum logic [2:0] {S_IDLE, S_COMPARE, S_SETUP, S_REFINE, S_REMAIN} divState_t;

  divState_t state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (start) begin
          strobe.loadOps = 1'b1;
          nextState      = S_COMPARE;
        end
      end
      S_COMPARE: begin
        if (status.divZero) begin
          strobe.flagZero = 1'b1;
          nextState       = S_IDLE;
        end else if (status.divGreater) begin
          nextState = S_REMAIN;
        end else if (status.divEqual) begin
          strobe.setQuotOne = 1'b1;
          nextState         = S_REMAIN;
        end else begin
          nextState = S_SETUP;
        end
      end
      S_SETUP: begin
        if (status.canDouble) begin
          strobe.shiftUp = 1'b1;
        end else begin
          strobe.initDiff = 1'b1;
          nextState       = status.expIsZero ? S_REMAIN : S_REFINE;
        end
      end
      S_REFINE: begin
        strobe.stepDown = 1'b1;
        if (status.lastStep) nextState = S_REMAIN;
      end
      S_REMAIN: begin
        strobe.finishRem = 1'b1;
        nextState        = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= strobe.finishRem | strobe.flagZero;
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/rns_divider.sv
module rns_divider
  import rns_div_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [VEC_W-1:0]  dividendRes,
  input  logic [VEC_W-1:0]  divisorRes,
  output logic              busy,
  output logic              done,
  output logic              divZeroErr,
  output logic [VEC_W-1:0]  quotientRes,
  output logic [VEC_W-1:0]  remainderRes
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  rns_div_control ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .status (status),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  rns_div_datapath dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .dividendRes  (dividendRes),
    .divisorRes   (divisorRes),
    .status       (status),
    .divZeroErr   (divZeroErr),
    .quotientRes  (quotientRes),
    .remainderRes (remainderRes)
  );

endmodule

// File: rtl/rns_div_checker.sv
module rns_div_checker
  import rns_div_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             divZeroErr,
  input logic [VEC_W-1:0] quotientRes,
  input logic [VEC_W-1:0] remainderRes
);

  // R6: done lasts a single cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);

  // R6: busy is low once the result is flagged
  p_done_not_busy_r6: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);

  // R6: an accepted start makes the block busy
  p_busy_after_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R7: results only move together with done
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(quotientRes) || !$stable(remainderRes)) |-> done);

  // R8: zero divisor yields zero results
  p_zero_div_out_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && divZeroErr) |-> (quotientRes == '0 && remainderRes == '0));

  // R4: every residue field is below its modulus
  p_res_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (quotientRes[3:0] < 4'd5 && quotientRes[7:4] < 4'd7 &&
              quotientRes[11:8] < 4'd9 && quotientRes[15:12] < 4'd11 &&
              remainderRes[3:0] < 4'd5 && remainderRes[7:4] < 4'd7 &&
              remainderRes[11:8] < 4'd9 && remainderRes[15:12] < 4'd11));

endmodule

bind rns_divider rns_div_checker chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .divZeroErr   (divZeroErr),
  .quotientRes  (quotientRes),
  .remainderRes (remainderRes)
);

// File: tb/rns_divider_tb.sv
module rns_divider_tb_top;
  import rns_div_pkg::*;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [VEC_W-1:0] dividendRes = '0;
  logic [VEC_W-1:0] divisorRes = '0;
  logic             busy, done, divZeroErr;
  logic [VEC_W-1:0] quotientRes, remainderRes;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  rns_divider dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .dividendRes  (dividendRes),
    .divisorRes   (divisorRes),
    .busy         (busy),
    .done         (done),
    .divZeroErr   (divZeroErr),
    .quotientRes  (quotientRes),
    .remainderRes (remainderRes)
  );

  function automatic logic [VEC_W-1:0] enc(input int x);
    logic [VEC_W-1:0] v;
    for (int k = 0; k < NUM_MOD; k++) v[k*RES_W +: RES_W] = RES_W'(x % int'(MODULI[k]));
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input int a, input int b);
    @(negedge clk);
    dividendRes = enc(a);
    divisorRes  = enc(b);
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // waits for done, checks the handshake (R6)
  task automatic waitDone(input string tag);
    int n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, {tag, " R6 done seen"}, 32'(done), 32'd1);
    check(busy == 1'b0, {tag, " R6 busy low at done"}, 32'(busy), 32'd0);
  endtask

  task automatic afterDone(input string tag);
    @(negedge clk);
    check(done == 1'b0, {tag, " R6 done one cycle"}, 32'(done), 32'd0);
  endtask

  task automatic runCase(input int a, input int b, input string tag);
    issue(a, b);
    check(busy == 1'b1, {tag, " R6 busy after start"}, 32'(busy), 32'd1);
    waitDone(tag);
    check(quotientRes == enc(a / b), {tag, " quotient"}, 32'(quotientRes), 32'(enc(a / b)));
    check(remainderRes == enc(a % b), {tag, " remainder"}, 32'(remainderRes), 32'(enc(a % b)));
    check(divZeroErr == 1'b0, {tag, " no error"}, 32'(divZeroErr), 32'd0);
    afterDone(tag);
  endtask

  task automatic testReset();
    check(busy == 0 && done == 0 && divZeroErr == 0, "R1 control outputs idle",
          {29'd0, busy, done, divZeroErr}, 32'd0);
    check(quotientRes == '0 && remainderRes == '0, "R1 results zero",
          {quotientRes, remainderRes}, 32'd0);
  endtask

  task automatic testSmaller();
    runCase(5, 9, "R2 smaller");
    runCase(0, 7, "R2 zero dividend");
    runCase(3463, 3464, "R2 adjacent");
  endtask

  task automatic testEqual();
    runCase(1234, 1234, "R3 equal");
    runCase(1, 1, "R3 unit");
  endtask

  task automatic testGeneral();
    runCase(100, 7, "R4 mid");
    runCase(1000, 33, "R4 mixed bits");
    runCase(3000, 1499, "R4 two");
    runCase(17, 16, "R4 exponent zero");
    runCase(1024, 4, "R4 exact fit");
    runCase(999, 37, "R4 exact multiple");
  endtask

  task automatic testLarge();
    runCase(3464, 1, "R5 full range");
    runCase(3464, 2, "R5 half range");
    runCase(2048, 1, "R5 top power");
  endtask

  task automatic testIgnoreStart();
    logic [VEC_W-1:0] qBefore;
    issue(100, 7);
    qBefore = quotientRes;
    dividendRes = enc(50);
    divisorRes  = enc(50);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(quotientRes == qBefore, "R7 result held while busy", 32'(quotientRes), 32'(qBefore));
    waitDone("R7 busy start");
    check(quotientRes == enc(14), "R7 ignored start quotient", 32'(quotientRes), 32'(enc(14)));
    check(remainderRes == enc(2), "R7 ignored start remainder", 32'(remainderRes), 32'(enc(2)));
    afterDone("R7");
    check(busy == 1'b0, "R7 no second run", 32'(busy), 32'd0);
  endtask

  task automatic testDivZero();
    issue(123, 0);
    waitDone("R8 zero divisor");
    check(divZeroErr == 1'b1, "R8 error flag", 32'(divZeroErr), 32'd1);
    check(quotientRes == '0 && remainderRes == '0, "R8 zero outputs",
          {quotientRes, remainderRes}, 32'd0);
    afterDone("R8");
    runCase(20, 3, "R9 error cleared");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSmaller();
    testEqual();
    testGeneral();
    testLarge();
    testIgnoreStart();
    testDivZero();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule